// File: doc/BRIEF.md
# UART Transmit Framer with Idle and Break Frames

This block turns parallel words into a serial line. Each data frame is a low start bit, then the data bits with the least significant bit first, then a high stop bit. When parity is on, the parity bit takes the slot of the last data bit, so the frame does not get longer. The line rests high.

Two special frames can also be requested with single-cycle pulses. An idle frame holds the line high for exactly one data-frame length. A break frame drives the line low for one data-frame length and then ends with one high stop bit. The length of both special frames follows the word-length setting that is in force when the frame starts.

An external baud tick paces all timing. Frames start only on a tick, and each bit lasts one tick period. The block holds one data word. Requests that arrive while a frame is on the line wait for it to finish and are then served in priority order.

Top module: `uart_frame_tx`

## Requirements
- R1: A data frame is one 0 start bit, then W data bits with the least significant bit first, then one 1 stop bit. W is 9 when `word_long`=1 and 8 when `word_long`=0. In 8-bit mode, `tx_data[8]` has no effect on the line.
- R2: With `par_en`=1, the last data-bit position (bit W-1) carries parity computed over `tx_data[W-2:0]`. `par_odd`=0 gives even parity: the parity bit and those data bits together hold an even number of ones. `par_odd`=1 gives odd parity.
- R3: An idle frame is W+2 bit periods of 1 with `busy` high.
- R4: A break frame is W+2 bit periods of 0 followed by one stop bit of 1.
- R5: A break request wins over an idle request, and an idle request wins over a held data word. Anything pending waits until the frame on the line has finished.
- R6: Frames start only on a baud tick, and every bit lasts exactly one tick period. Pending work starts on the tick that ends the previous frame, with no idle gap.
- R7: `busy` is high from the start of the first bit until the last stop bit has ended. While `busy` is low, `txd` is 1. After reset, `txd`=1, `busy`=0 and `tx_ready`=1.
- R8: `tx_ready` is high while the one-word holding slot is empty. A word is taken on a cycle with `tx_valid` and `tx_ready` both high. Idle and break requests are one-cycle pulses that are latched until served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| word_long | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity replaces the last data bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | A word is offered |
| tx_ready | output | 1 | Holding slot is empty |
| idle_req | input | 1 | Pulse requesting an idle frame |
| break_req | input | 1 | Pulse requesting a break frame |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is on the line |

## Verification
The hardest case to reach is three-way contention: a data word, an idle request and a break request all pending at once behind a frame that is already on the line. The stimulus starts one data frame. As soon as `busy` rises, it offers a second word and pulses both requests in the same cycle. The scoreboard then expects break, idle and the second word, in that order, with no idle bit period between them. Word-length and parity settings are also varied across frames so that the parity slot and the sizes of the special frames move.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_IDLE  = 2'd1,
    K_BREAK = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/uart_tx_sched.sv
module uart_tx_sched
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              idle_req,
  input  logic              break_req,
  input  logic              start,
  output logic              have_work,
  output frame_kind_e       kind,
  output logic [DATA_W-1:0] data_q
);
  logic hold_v, pend_idle, pend_brk;

  assign tx_ready  = !hold_v;
  assign have_work = pend_brk || pend_idle || hold_v;
  assign kind      = pend_brk ? K_BREAK : (pend_idle ? K_IDLE : K_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      data_q    <= '0;
      pend_idle <= 1'b0;
      pend_brk  <= 1'b0;
    end else begin
      pend_brk  <= (pend_brk && !start) || break_req;
      pend_idle <= (pend_idle && !(start && !pend_brk)) || idle_req;
      if (tx_valid && !hold_v) begin
        hold_v <= 1'b1;
        data_q <= tx_data;
      end else if (start && !pend_brk && !pend_idle) begin
        hold_v <= 1'b0;
      end
    end
  end

  // a held word stays put until a data frame takes it
  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !start) |=> (hold_v && $stable(data_q)));
endmodule

// File: rtl/uart_tx_build.sv
module uart_tx_build
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FW    = DATA_W + 3,
  localparam int CW    = $clog2(FW + 1)
) (
  input  frame_kind_e       kind,
  input  logic [DATA_W-1:0] data,
  input  logic              word_long,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     len
);
  always_comb begin
    int  w;
    logic par;
    w     = word_long ? DATA_W : DATA_W - 1;
    par   = par_odd;
    frame = '1;
    for (int i = 0; i < DATA_W - 1; i++)
      if (i < w - 1) par = par ^ data[i];
    case (kind)
      K_DATA: begin
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++)
          if (i < w) frame[i+1] = (par_en && i == w - 1) ? par : data[i];
      end
      K_BREAK: begin
        for (int i = 0; i < FW; i++)
          if (i < w + 2) frame[i] = 1'b0;
      end
      default: frame = '1;
    endcase
    len = (kind == K_BREAK) ? CW'(w + 3) : CW'(w + 2);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FW    = DATA_W + 3,
  localparam int CW    = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          start,
  input  frame_kind_e   kind,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] len,
  output logic          can_load,
  output logic          txd,
  output logic          busy
);
  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;

  assign can_load = baud_tick && (!busy || cnt == '0);
  assign txd      = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      sh   <= frame;
      cnt  <= len - CW'(1);
      busy <= 1'b1;
    end else if (baud_tick && busy) begin
      if (cnt != '0) begin
        sh  <= {1'b1, sh[FW-1:1]};
        cnt <= cnt - CW'(1);
      end else begin
        sh   <= '1;
        busy <= 1'b0;
      end
    end
  end

  assert_line_rest_high_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_bit_held_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(baud_tick) && $past(busy)) |-> $stable(txd));
  assert_busy_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(baud_tick));
  assert_data_start_low_R1: assert property (@(posedge clk) disable iff (rst)
    (start && kind == K_DATA) |=> !txd);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    (start && kind == K_IDLE) |=> (txd && busy));
  assert_break_low_R4: assert property (@(posedge clk) disable iff (rst)
    (start && kind == K_BREAK) |=> !txd);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int FW    = DATA_W + 3,
  localparam int CW    = $clog2(FW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              word_long,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              idle_req,
  input  logic              break_req,
  output logic              txd,
  output logic              busy
);
  frame_kind_e       kind;
  logic [DATA_W-1:0] data_q;
  logic              have_work, can_load, start;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     len;

  assign start = can_load && have_work;

  uart_tx_sched #(.DATA_W(DATA_W)) u_sched (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .idle_req(idle_req), .break_req(break_req),
    .start(start), .have_work(have_work), .kind(kind), .data_q(data_q)
  );

  uart_tx_build #(.DATA_W(DATA_W)) u_build (
    .kind(kind), .data(data_q), .word_long(word_long), .par_en(par_en),
    .par_odd(par_odd), .frame(frame), .len(len)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .start(start),
    .kind(kind), .frame(frame), .len(len), .can_load(can_load),
    .txd(txd), .busy(busy)
  );
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int DIV = 4;
  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0;
  logic word_long = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0, idle_req = 1'b0, break_req = 1'b0;
  logic tx_ready, txd, busy;

  int n_vec = 0, n_bad = 0;
  logic  exp_b[$];
  string exp_t[$];
  bit cont_mode = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .word_long(word_long),
    .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .idle_req(idle_req),
    .break_req(break_req), .txd(txd), .busy(busy)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic push_bit(input logic b, input string tag);
    exp_b.push_back(b);
    exp_t.push_back(tag);
  endtask

  // kind 0 data, 1 idle, 2 break; uses the current config
  task automatic push_frame(input int kind, input logic [8:0] d, input string tag);
    int w;
    logic p;
    w = word_long ? 9 : 8;
    p = par_odd;
    for (int i = 0; i < w - 1; i++) p = p ^ d[i];
    if (kind == 0) begin
      push_bit(1'b0, tag);
      for (int i = 0; i < w; i++)
        push_bit((par_en && i == w - 1) ? p : d[i], tag);
      push_bit(1'b1, tag);
    end else if (kind == 1) begin
      for (int i = 0; i < w + 2; i++) push_bit(1'b1, tag);
    end else begin
      for (int i = 0; i < w + 2; i++) push_bit(1'b0, tag);
      push_bit(1'b1, tag);
    end
  endtask

  task automatic send_data(input logic [8:0] d, input string tag);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    push_frame(0, d, tag);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pulse_req(input bit brk, input string tag);
    @(negedge clk);
    push_frame(brk ? 2 : 1, '0, tag);
    if (brk) break_req = 1'b1; else idle_req = 1'b1;
    @(negedge clk);
    break_req = 1'b0;
    idle_req  = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_b.size() != 0 || busy) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (exp_b.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R7: frame cut short, %0d bits missing, expected 0", exp_b.size());
      exp_b.delete(); exp_t.delete();
    end
    cont_mode = 1'b0;
  endtask

  // tick generator and scoreboard monitor: sample each bit just before its closing tick
  initial begin
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      repeat (DIV - 1) @(negedge clk);
      if (busy) begin
        if (exp_b.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R7: extra busy bit txd=%b, expected no frame", txd);
        end else begin
          logic  eb;
          string et;
          eb = exp_b.pop_front();
          et = exp_t.pop_front();
          chk(txd, eb, et);
        end
      end else if (cont_mode && exp_b.size() != 0) begin
        n_vec++; n_bad++;
        $display("FAIL R6: gap between frames busy=%b, expected 1", busy);
      end
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  initial begin
    #(8 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd, 1'b1, "R7 reset txd");
    chk(busy, 1'b0, "R7 reset busy");
    chk(tx_ready, 1'b1, "R7 reset ready");

    // R1: plain 8-bit and 9-bit frames, bit 8 ignored in 8-bit mode
    send_data(9'h0A5, "R1 8b A5"); drain();
    send_data(9'h000, "R1 8b 00"); drain();
    send_data(9'h1FF, "R1 8b FF bit8 ignored"); drain();
    word_long = 1'b1;
    send_data(9'h1A5, "R1 9b 1A5"); drain();
    send_data(9'h0FF, "R1 9b 0FF"); drain();

    // R2: parity in the last data slot
    par_en = 1'b1; word_long = 1'b0; par_odd = 1'b0;
    send_data(9'h007, "R2 8b even"); drain();
    par_odd = 1'b1;
    send_data(9'h007, "R2 8b odd"); drain();
    send_data(9'h0FE, "R2 8b odd msb replaced"); drain();
    word_long = 1'b1;
    send_data(9'h0C3, "R2 9b odd"); drain();
    par_odd = 1'b0;
    send_data(9'h1C3, "R2 9b even"); drain();
    par_en = 1'b0;

    // R3 / R4: special frames sized by the word-length setting
    word_long = 1'b0;
    pulse_req(1'b0, "R3 idle 8b"); drain();
    pulse_req(1'b1, "R4 break 8b"); drain();
    word_long = 1'b1;
    pulse_req(1'b0, "R3 idle 9b"); drain();
    pulse_req(1'b1, "R4 break 9b"); drain();

    // R5 / R6 / R8: contention behind a running frame, served back to back
    word_long = 1'b0;
    send_data(9'h03C, "R5 first");
    @(negedge clk);
    while (!busy) @(negedge clk);
    cont_mode = 1'b1;
    push_frame(2, '0, "R5 break first");
    push_frame(1, '0, "R5 idle second");
    push_frame(0, 9'h0C9, "R5 data last");
    tx_data = 9'h0C9; tx_valid = 1'b1; idle_req = 1'b1; break_req = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0;
    chk(tx_ready, 1'b0, "R8 slot full after accept");
    drain();
    chk(tx_ready, 1'b1, "R8 slot empty after send");

    // R6: two data words back to back
    send_data(9'h055, "R6 b2b a");
    @(negedge clk);
    while (!busy) @(negedge clk);
    cont_mode = 1'b1;
    send_data(9'h0AA, "R6 b2b b");
    drain();
    chk(txd, 1'b1, "R7 line high after drain");
    chk(busy, 1'b0, "R7 busy low after drain");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule